// File: doc/BRIEF.md
# Adaptive-Step PWM Threshold Servo

This block steers the duty cycle of a PWM output so that a filtered copy of it tracks an analog slicing threshold. An external comparator reports, on a single wire, whether the filtered level sits above or below the target. The block samples that wire on a slow regulation strobe. A high reading pulls the duty down and a low reading pushes it up. The filter and the comparator sit outside the block.

The amount moved per strobe adapts to the feedback. Each time the comparator reading flips between two strobes, the step drops to one count. While the reading keeps the same value, the step grows by one count per strobe up to a ceiling. The loop therefore closes in quickly from far away and then dithers in single counts around the threshold. A step that stays near its ceiling means the loop cannot reach the threshold, and a flag reports this.

The PWM carrier has a period of 2^PWM_BITS counts, each count lasting PWM_DIV clocks. The duty in use is taken over only at the end of a carrier period, so no pulse is ever cut short or stretched. With the defaults, the 125 MHz clock and a 100 ms strobe, the carrier runs at about 61 kHz.

Top module: `pwm_level_servo`

## Requirements
- R1: After reset the duty is 750, the step is 50, the failure flag is low, and the PWM output is high for exactly 750 of every 1024 counts.
- R2: On a regulation event a sampled comparator level of 1 lowers the duty by the new step, and a level of 0 raises it by the new step.
- R3: The duty saturates at 0 and at 1000 and never wraps. A duty of 0 gives a constantly low output, and a duty of 1000 gives 1000 high counts per period.
- R4: When the sampled level differs from the level sampled on the previous regulation event, the new step is 1.
- R5: When the level has not changed, the step grows by 1 per regulation event until it reaches 100, then stays at 100.
- R6: The first regulation event after reset has no previous level to compare against, so it counts as "no change" and the step goes from 50 to 51.
- R7: The failure flag is a registered output that is high exactly while the step is above 95. It drops on the same event that collapses the step.
- R8: A new duty value reaches the PWM comparator only at a carrier period boundary. A pulse in progress keeps the length of the old duty.
- R9: A regulation event happens once every TICK_DIV pulses of tick_i. With TICK_DIV=1 every pulse is an event.
- R10: cmp_i passes through SYNC_STAGES flip-flops and is used only on a regulation event. Changes of cmp_i between events leave the duty unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Regulation strobe, one clock wide per pulse |
| cmp_i | input | 1 | Comparator feedback: 1 means the filtered level is above the threshold |
| pwm_o | output | 1 | Registered PWM output |
| fail_o | output | 1 | Registered regulation-failure flag |

## Verification
The main instance is built with PWM_DIV=1. Its carrier period is then 1024 clocks, so the number of high cycles in any 1024-cycle window equals the duty in use, and every duty change can be seen at the pin within a few thousand cycles. A second instance is built with TICK_DIV=3 and shares the same strobe. This shows that only every third pulse moves its duty. Because strobes can be packed a few clocks apart, the bench can drive the step all the way to its ceiling and hold it there for 40 more events. It can also drive the duty into both saturation limits, all without waiting for real 100 ms ticks.

// File: rtl/lvlservo_pkg.sv
package lvlservo_pkg;

  // Remembered comparator sample from the previous regulation event.
  typedef struct packed {
    logic valid;
    logic level;
  } fb_state_t;

endpackage

// File: rtl/lvlservo_sync.sv
module lvlservo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[i] <= 1'b0;
          else     sh_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[i] <= 1'b0;
          else     sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/lvlservo_tick.sv
module lvlservo_tick #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic tick_o
);

  logic tick_q;

  generate
    if (TICK_DIV <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick_i;
      end
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      logic          last;
      assign last = (cnt_q == CW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          tick_q <= tick_i && last;
          if (tick_i) cnt_q <= last ? '0 : cnt_q + CW'(1);
        end
      end
      // R9: the strobe counter never leaves its range
      a_r9_div_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(TICK_DIV - 1));
    end
  endgenerate

  assign tick_o = tick_q;

endmodule

// File: rtl/lvlservo_step.sv
module lvlservo_step
  import lvlservo_pkg::*;
#(
  parameter int DUTY_MAX   = 1000,
  parameter int DUTY_INIT  = 750,
  parameter int STEP_INIT  = 50,
  parameter int STEP_MAX   = 100,
  parameter int FAIL_ABOVE = 95,
  parameter int DUTY_W     = $clog2(DUTY_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              lvl_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              fail_o
);

  localparam int STEP_W = $clog2(STEP_MAX + 1);
  localparam int SUM_W  = DUTY_W + 1;

  fb_state_t         fb_q;
  logic [STEP_W-1:0] step_q, step_n;
  logic [DUTY_W-1:0] duty_q, duty_n;
  logic              fail_q;
  logic              toggle;
  logic [SUM_W-1:0]  step_ext, duty_ext, up_sum;

  always_comb begin
    toggle = fb_q.valid && (fb_q.level != lvl_i);
    if (toggle)                              step_n = STEP_W'(1);
    else if (step_q < STEP_W'(STEP_MAX))     step_n = step_q + STEP_W'(1);
    else                                     step_n = step_q;
    step_ext = SUM_W'(step_n);
    duty_ext = SUM_W'(duty_q);
    up_sum   = duty_ext + step_ext;
    if (lvl_i)
      duty_n = (duty_ext > step_ext) ? DUTY_W'(duty_ext - step_ext) : '0;
    else
      duty_n = (up_sum < SUM_W'(DUTY_MAX)) ? DUTY_W'(up_sum) : DUTY_W'(DUTY_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q   <= '0;
      step_q <= STEP_W'(STEP_INIT);
      duty_q <= DUTY_W'(DUTY_INIT);
      fail_q <= 1'b0;
    end else if (tick_i) begin
      fb_q.valid <= 1'b1;
      fb_q.level <= lvl_i;
      step_q     <= step_n;
      duty_q     <= duty_n;
      fail_q     <= (step_n > STEP_W'(FAIL_ABOVE));
    end
  end

  assign duty_o = duty_q;
  assign fail_o = fail_q;

  // R3: duty stays inside the legal range
  a_r3_duty_range: assert property (@(posedge clk) disable iff (rst)
    duty_q <= DUTY_W'(DUTY_MAX));
  // R5: step stays between 1 and its ceiling
  a_r5_step_bounds: assert property (@(posedge clk) disable iff (rst)
    (step_q >= STEP_W'(1)) && (step_q <= STEP_W'(STEP_MAX)));
  // R4: a level change collapses the step
  a_r4_toggle_min: assert property (@(posedge clk) disable iff (rst)
    (tick_i && fb_q.valid && (fb_q.level != lvl_i)) |=> (step_q == STEP_W'(1)));
  // R6: first event after reset only grows the step
  a_r6_first_grow: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !fb_q.valid && (step_q < STEP_W'(STEP_MAX)))
      |=> (step_q == $past(step_q) + STEP_W'(1)));
  // R10: nothing moves between regulation events
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(step_q) && $stable(duty_q)));
  // R7: flag follows the stored step
  a_r7_fail_track: assert property (@(posedge clk) disable iff (rst)
    fail_q == (step_q > STEP_W'(FAIL_ABOVE)));

endmodule

// File: rtl/lvlservo_pwm.sv
module lvlservo_pwm #(
  parameter int PWM_BITS = 10,
  parameter int PWM_DIV  = 2,
  parameter int CMP_INIT = 750
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PWM_BITS-1:0] duty_i,
  output logic                pwm_o
);

  logic                adv;
  logic                wrap;
  logic [PWM_BITS-1:0] cnt_q;
  logic [PWM_BITS-1:0] cmp_q;
  logic                pwm_q;

  generate
    if (PWM_DIV <= 1) begin : g_nodiv
      assign adv = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PWM_DIV);
      logic [PW-1:0] pre_q;
      assign adv = (pre_q == PW'(PWM_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)      pre_q <= '0;
        else if (adv) pre_q <= '0;
        else          pre_q <= pre_q + PW'(1);
      end
    end
  endgenerate

  assign wrap = adv && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmp_q <= PWM_BITS'(CMP_INIT);
      pwm_q <= 1'b0;
    end else begin
      if (adv)  cnt_q <= cnt_q + PWM_BITS'(1);
      if (wrap) cmp_q <= duty_i;
      pwm_q <= (cnt_q < cmp_q);
    end
  end

  assign pwm_o = pwm_q;

  // R8: compare value changes only at the period boundary
  a_r8_load_boundary: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cmp_q));

endmodule

// File: rtl/pwm_level_servo.sv
module pwm_level_servo #(
  parameter int DUTY_MAX    = 1000,
  parameter int DUTY_INIT   = 750,
  parameter int STEP_INIT   = 50,
  parameter int STEP_MAX    = 100,
  parameter int FAIL_ABOVE  = 95,
  parameter int PWM_BITS    = 10,
  parameter int PWM_DIV     = 2,
  parameter int TICK_DIV    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic cmp_i,
  output logic pwm_o,
  output logic fail_o
);

  localparam int DUTY_W = $clog2(DUTY_MAX + 1);

  logic              lvl_s;
  logic              reg_tick;
  logic [DUTY_W-1:0] duty;

  lvlservo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (cmp_i), .q_o (lvl_s)
  );

  lvlservo_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk), .rst (rst), .tick_i (tick_i), .tick_o (reg_tick)
  );

  lvlservo_step #(
    .DUTY_MAX (DUTY_MAX), .DUTY_INIT (DUTY_INIT), .STEP_INIT (STEP_INIT),
    .STEP_MAX (STEP_MAX), .FAIL_ABOVE (FAIL_ABOVE), .DUTY_W (DUTY_W)
  ) u_step (
    .clk (clk), .rst (rst), .tick_i (reg_tick), .lvl_i (lvl_s),
    .duty_o (duty), .fail_o (fail_o)
  );

  lvlservo_pwm #(
    .PWM_BITS (PWM_BITS), .PWM_DIV (PWM_DIV), .CMP_INIT (DUTY_INIT)
  ) u_pwm (
    .clk (clk), .rst (rst), .duty_i (PWM_BITS'(duty)), .pwm_o (pwm_o)
  );

endmodule

// File: tb/pwm_level_servo_bench.sv
module pwm_level_servo_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic cmp = 1'b0;
  logic pwm_a, fail_a, pwm_b, fail_b;

  always #4 clk = ~clk;

  pwm_level_servo #(.PWM_DIV(1)) u_pwm_level_servo (
    .clk (clk), .rst (rst), .tick_i (tick), .cmp_i (cmp),
    .pwm_o (pwm_a), .fail_o (fail_a)
  );

  pwm_level_servo #(.PWM_DIV(1), .TICK_DIV(3)) u_pwm_level_servo_div3 (
    .clk (clk), .rst (rst), .tick_i (tick), .cmp_i (cmp),
    .pwm_o (pwm_b), .fail_o (fail_b)
  );

  typedef struct {
    int    exp;
    bit    sel;
    string tag;
  } item_t;

  item_t q[$];
  event  meas_ev, meas_done;
  int    checks = 0;
  int    errors = 0;

  int m_duty = 750, m_step = 50, m_last = 0;
  bit m_valid = 1'b0;

  function automatic void model_step(input int lvl);
    if (m_valid && lvl != m_last) m_step = 1;
    else if (m_step < 100)        m_step++;
    if (lvl != 0) m_duty = (m_duty > m_step) ? m_duty - m_step : 0;
    else          m_duty = (m_duty + m_step < 1000) ? m_duty + m_step : 1000;
    m_last  = lvl;
    m_valid = 1'b1;
  endfunction

  task automatic tick_once(input int lvl);
    cmp = (lvl != 0);
    repeat (4) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    model_step(lvl);
  endtask

  task automatic check_duty(input int exp, input bit sel, input string tag);
    item_t it;
    it.exp = exp; it.sel = sel; it.tag = tag;
    q.push_back(it);
    -> meas_ev;
    @(meas_done);
  endtask

  task automatic check_flag(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: fail_o actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Monitor: waits for the old compare to leave, then counts one period.
  initial begin
    forever begin
      item_t it;
      int    cnt;
      @(meas_ev);
      it = q.pop_front();
      repeat (2100) @(negedge clk);
      cnt = 0;
      repeat (1024) begin
        @(negedge clk);
        cnt += it.sel ? int'(pwm_b) : int'(pwm_a);
      end
      checks++;
      if (cnt != it.exp) begin
        errors++;
        $display("FAIL %s: high count actual %0d expected %0d", it.tag, cnt, it.exp);
      end
      -> meas_done;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int old_d, len;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_flag(fail_a, 1'b0, "R1 reset flag");
    check_duty(750, 1'b0, "R1 reset duty");
    check_duty(750, 1'b1, "R1 reset duty div3");

    // R10: wiggle comparator with no event
    for (int i = 0; i < 6; i++) begin
      cmp = ~cmp;
      repeat (7) @(negedge clk);
    end
    check_duty(750, 1'b0, "R10 no event no change");

    tick_once(1);
    check_duty(m_duty, 1'b0, "R6 R2 first event lowers by 51");
    check_duty(750, 1'b1, "R9 one of three strobes");
    tick_once(1);
    tick_once(1);
    check_duty(m_duty, 1'b0, "R5 growing step");
    check_duty(699, 1'b1, "R9 third strobe moves duty");

    repeat (15) tick_once(1);
    check_duty(0, 1'b0, "R3 low saturation");
    while (m_step < 95) tick_once(1);
    check_flag(fail_a, 1'b0, "R7 step 95 flag low");
    tick_once(1);
    check_flag(fail_a, 1'b1, "R7 step 96 flag high");
    repeat (40) tick_once(1);
    check_flag(fail_a, 1'b1, "R5 step held at ceiling");

    tick_once(0);
    check_flag(fail_a, 1'b0, "R7 flag drops on toggle");
    check_duty(m_duty, 1'b0, "R4 toggle gives step 1");
    repeat (10) tick_once(0);
    check_duty(m_duty, 1'b0, "R2 R5 rising ramp");
    repeat (60) tick_once(0);
    check_duty(1000, 1'b0, "R3 high saturation");

    tick_once(1); tick_once(1); tick_once(1);
    tick_once(0); tick_once(1); tick_once(0);
    check_duty(m_duty, 1'b0, "R4 dither around level");

    while (m_duty >= 600) tick_once(1);
    check_duty(m_duty, 1'b0, "R2 falling ramp");

    // R8: update in the middle of a high pulse
    old_d = m_duty;
    @(posedge pwm_a);
    len = 0;
    fork
      begin
        @(negedge clk);
        while (pwm_a) begin
          len++;
          @(negedge clk);
        end
      end
      begin
        repeat (200) @(negedge clk);
        tick_once(0);
      end
    join
    checks++;
    if (len != old_d) begin
      errors++;
      $display("FAIL R8 pulse length: actual %0d expected %0d", len, old_d);
    end
    check_duty(m_duty, 1'b0, "R8 new duty next period");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule